// File: doc/BRIEF.md
# Multichannel Square-Wave Quadrature Demodulator

This block recovers the amplitude of a modulated signal on several sensor channels. It does this by synchronous detection against a square-wave reference. Samples arrive one channel at a time. Each sample carries a channel index and a valid strobe. A sample tick is complete once the highest-numbered channel has delivered its sample. Every modulation cycle spans 20 ticks, split into four quarters of 5 ticks each.

For each channel, the 5 samples of a quarter are added into a group value. The group value is then weighted by +1 or -1 to produce an in-phase (I) term and a quadrature (Q) term. At the end of each cycle, the cycle's I sum and Q sum enter a per-channel boxcar window that holds the last M cycles. The window is updated incrementally with a circular history buffer: the new sum is added and the oldest sum is subtracted. The reported amplitude is |I| + |Q| of the window sums. One result is produced per channel per cycle.

A sync input aligns the shared phase counters to the reference. The block processes one sample per clock, so at least K clocks must separate the starts of consecutive ticks.

Top module: `quad_square_demod`

## Requirements
- R1: Each channel's samples are summed in groups of 5 consecutive ticks. Ticks are numbered 0..19 within a cycle, and quarter q covers ticks 5q..5q+4. A tick closes when the sample with `s_chan == K-1` is accepted.
- R2: The I weight applied to a group is +1 in quarters 0 and 1, and -1 in quarters 2 and 3.
- R3: The Q weight applied to a group is -1 in quarters 0 and 3, and +1 in quarters 1 and 2.
- R4: A channel's sample at tick 19 produces a result. One clock after that sample is accepted, `out_valid` pulses for one clock, with `out_chan` set to the channel. `out_mag` equals |ΣI| + |ΣQ|, where each sum covers that channel's last M cycle sums.
- R5: `out_valid` stays low for each channel's first M-1 cycles after reset. It first pulses at the end of the M-th cycle.
- R6: A sample with `sync` high and `s_chan == 0` makes its tick tick 0 of quarter 0. Any partial cycle is dropped, and the history of completed cycles is kept.
- R7: Clocks with `s_valid` low change nothing, whatever `s_data`, `s_chan` and `sync` carry. Idle gaps between samples do not alter any result.
- R8: After reset, `out_valid` and `out_mag` are 0, and all sums and history entries are zero.
- R9: At full scale the result does not overflow. It never exceeds 10·M·(2^W−1): 327600 for the defaults, which is reached when samples equal 4095 in quarters 0 and 1 and 0 elsewhere.
- R10: A channel held at any constant level reports `out_mag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Phase alignment, sampled with the channel-0 sample |
| s_valid | input | 1 | Sample strobe |
| s_chan | input | CW | Channel index of the sample |
| s_data | input | W | Unsigned ADC sample |
| out_valid | output | 1 | One-clock result strobe |
| out_chan | output | CW | Channel of the result |
| out_mag | output | AW | Amplitude estimate |q|I|+|Q| |

## Verification
The end of a quarter and the end of a cycle fall on the same sample at tick 19, so the group sum, the signed cycle sum and the window update must all fold into one result. Patterns that vary from sample to sample check that the fourth group is counted exactly once. A second coincidence is a sync that arrives while a window-wrapping cycle is half built: the bench pulses sync on the 8th tick of a cycle and judges the next results against a model. That model discards the partial cycle and keeps the history, so a wrong discard or a corrupted history changes every channel's magnitude.

// File: rtl/quad_square_demod.sv
module quad_square_demod #(
  parameter int W = 12,
  parameter int K = 4,
  parameter int M = 8,
  localparam int CW = (K > 1) ? $clog2(K) : 1,
  localparam int AW = W + $clog2(20 * M) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  input  logic          s_valid,
  input  logic [CW-1:0] s_chan,
  input  logic [W-1:0]  s_data,
  output logic          out_valid,
  output logic [CW-1:0] out_chan,
  output logic [AW-1:0] out_mag
);
  localparam int PW = (M > 1) ? $clog2(M) : 1;
  localparam int GW = W + 3;

  logic [2:0]  sub;
  logic [1:0]  qtr;
  logic [PW-1:0] wp, fill;

  logic [GW-1:0]        grp   [K];
  logic signed [AW-1:0] cyc_i [K];
  logic signed [AW-1:0] cyc_q [K];
  logic signed [AW-1:0] run_i [K];
  logic signed [AW-1:0] run_q [K];
  logic signed [AW-1:0] hist_i [K][M];
  logic signed [AW-1:0] hist_q [K][M];

  wire restart = s_valid && sync && (s_chan == '0);
  wire last_ch = (s_chan == CW'(K - 1));
  wire [2:0] sub_e = restart ? 3'd0 : sub;
  wire [1:0] qtr_e = restart ? 2'd0 : qtr;
  wire grp_end = (sub_e == 3'd4);
  wire cyc_end = grp_end && (qtr_e == 2'd3);

  wire [GW-1:0] grp_n = ((sub_e == 3'd0) ? '0 : grp[s_chan]) + GW'(s_data);
  wire signed [AW-1:0] gval = $signed(AW'(grp_n));

  wire signed [AW-1:0] ci_base = (qtr_e == 2'd0) ? '0 : cyc_i[s_chan];
  wire signed [AW-1:0] cq_base = (qtr_e == 2'd0) ? '0 : cyc_q[s_chan];
  wire signed [AW-1:0] ci_n = qtr_e[1] ? ci_base - gval : ci_base + gval;
  wire signed [AW-1:0] cq_n = (qtr_e[1] == qtr_e[0]) ? cq_base - gval : cq_base + gval;

  wire signed [AW-1:0] ri_n = run_i[s_chan] + ci_n - hist_i[s_chan][wp];
  wire signed [AW-1:0] rq_n = run_q[s_chan] + cq_n - hist_q[s_chan][wp];
  wire [AW-1:0] ai = ri_n[AW-1] ? AW'(-ri_n) : AW'(ri_n);
  wire [AW-1:0] aq = rq_n[AW-1] ? AW'(-rq_n) : AW'(rq_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub       <= '0;
      qtr       <= '0;
      wp        <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_mag   <= '0;
      for (int c = 0; c < K; c++) begin
        grp[c]   <= '0;
        cyc_i[c] <= '0;
        cyc_q[c] <= '0;
        run_i[c] <= '0;
        run_q[c] <= '0;
        for (int m = 0; m < M; m++) begin
          hist_i[c][m] <= '0;
          hist_q[c][m] <= '0;
        end
      end
    end else begin
      out_valid <= 1'b0;
      if (s_valid) begin
        grp[s_chan] <= grp_n;
        if (grp_end) begin
          cyc_i[s_chan] <= ci_n;
          cyc_q[s_chan] <= cq_n;
        end
        if (cyc_end) begin
          run_i[s_chan]      <= ri_n;
          run_q[s_chan]      <= rq_n;
          hist_i[s_chan][wp] <= ci_n;
          hist_q[s_chan][wp] <= cq_n;
          out_valid          <= (fill == PW'(M - 1));
          out_chan           <= s_chan;
          out_mag            <= ai + aq;
        end
        if (last_ch) begin
          sub <= grp_end ? 3'd0 : sub_e + 3'd1;
          if (grp_end) qtr <= qtr_e + 2'd1;
          else         qtr <= qtr_e;
          if (cyc_end) begin
            wp <= (wp == PW'(M - 1)) ? '0 : wp + 1'b1;
            if (fill != PW'(M - 1)) fill <= fill + 1'b1;
          end
        end else if (restart) begin
          sub <= 3'd0;
          qtr <= 2'd0;
        end
      end
    end
  end
endmodule

module quad_square_demod_chk #(
  parameter int W  = 12,
  parameter int K  = 4,
  parameter int M  = 8,
  parameter int CW = 2,
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync,
  input logic          s_valid,
  input logic [CW-1:0] s_chan,
  input logic          out_valid,
  input logic [CW-1:0] out_chan,
  input logic [AW-1:0] out_mag,
  input logic [2:0]    sub,
  input logic [1:0]    qtr
);
  localparam logic [AW-1:0] MAXMAG = AW'(10 * M * ((1 << W) - 1));
  int done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 0;
    else if (s_valid && s_chan == CW'(K - 1) && sub == 3'd4 && qtr == 2'd3 && done < M)
      done <= done + 1;
  end

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n) sub <= 3'd4);
  assert_result_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(s_valid) && $past(s_chan) == out_chan));
  assert_no_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (done >= M - 1));
  assert_sync_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && sync && s_chan == '0) |=> (sub == 3'd0 && qtr == 2'd0));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> !out_valid);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mag <= MAXMAG);
endmodule

bind quad_square_demod quad_square_demod_chk #(.W(W), .K(K), .M(M), .CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync(sync), .s_valid(s_valid), .s_chan(s_chan),
  .out_valid(out_valid), .out_chan(out_chan), .out_mag(out_mag), .sub(sub), .qtr(qtr)
);

// File: tb/quad_square_demod_tb_top.sv
module quad_square_demod_tb_top;
  localparam int W = 12, K = 4, M = 8;
  localparam int CW = $clog2(K);
  localparam int AW = W + $clog2(20 * M) + 1;

  logic clk = 0, rst_n = 0, sync = 0, s_valid = 0;
  logic [CW-1:0] s_chan = '0;
  logic [W-1:0]  s_data = '0;
  logic out_valid;
  logic [CW-1:0] out_chan;
  logic [AW-1:0] out_mag;

  quad_square_demod #(.W(W), .K(K), .M(M)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync(sync), .s_valid(s_valid), .s_chan(s_chan),
    .s_data(s_data), .out_valid(out_valid), .out_chan(out_chan), .out_mag(out_mag));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, nout = 0;
  string cur_req = "R4";
  int mph, ncyc, gap;
  int samp [K][20];
  int hi [K][M];
  int hq [K][M];
  int exp_ch[$], exp_mag[$];
  int vals [K];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      nout++;
      if (exp_ch.size() == 0) chk(0, cur_req, "unexpected result", int'(out_chan), -1);
      else begin
        int ec, em;
        ec = exp_ch.pop_front();
        em = exp_mag.pop_front();
        chk(int'(out_chan) == ec, cur_req, "out_chan", int'(out_chan), ec);
        chk(int'(out_mag) == em, cur_req, "out_mag", int'(out_mag), em);
      end
    end
  end

  task automatic do_reset();
    rst_n = 0; s_valid = 0; sync = 0;
    repeat (3) @(negedge clk);
    mph = 0; ncyc = 0; nout = 0;
    exp_ch.delete(); exp_mag.delete();
    for (int c = 0; c < K; c++)
      for (int m = 0; m < M; m++) begin hi[c][m] = 0; hq[c][m] = 0; end
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic tick(input bit sy);
    if (sy) mph = 0;
    for (int c = 0; c < K; c++) begin
      @(negedge clk);
      s_valid = 1; s_chan = CW'(c); s_data = W'(vals[c]); sync = sy && (c == 0);
      samp[c][mph] = vals[c];
      if (mph == 19) begin
        int si, sq, ti, tq, q;
        si = 0; sq = 0;
        for (int p = 0; p < 20; p++) begin
          q = p / 5;
          si += (q < 2) ? samp[c][p] : -samp[c][p];
          sq += (q == 1 || q == 2) ? samp[c][p] : -samp[c][p];
        end
        hi[c][ncyc % M] = si;
        hq[c][ncyc % M] = sq;
        if (ncyc + 1 >= M) begin
          ti = 0; tq = 0;
          for (int m = 0; m < M; m++) begin ti += hi[c][m]; tq += hq[c][m]; end
          exp_ch.push_back(c);
          exp_mag.push_back((ti < 0 ? -ti : ti) + (tq < 0 ? -tq : tq));
        end
      end
    end
    if (mph == 19) ncyc++;
    mph = (mph + 1) % 20;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      s_valid = 0; sync = (g % 2 == 0); s_chan = CW'(g); s_data = 12'hABC + W'(g);
    end
    @(negedge clk);
    s_valid = 0; sync = 0;
  endtask

  function automatic int pat(input int kind, input int c, input int ph);
    int q;
    q = ph / 5;
    case (kind)
      0: return c * 1000 + 7;
      1: return (q < 2) ? 100 * (c + 1) : 0;
      2: return (q == 1 || q == 2) ? 150 * (c + 1) : 0;
      3: return (c * 37 + ph * ph * 11 + ph) % 4096;
      4: return (q < 2) ? 4095 : 0;
      default: return (q == 0) ? 300 + c : 20 * c;
    endcase
  endfunction

  task automatic run(input int kind, input int ticks);
    for (int t = 0; t < ticks; t++) begin
      for (int c = 0; c < K; c++) vals[c] = pat(kind, c, mph);
      tick(0);
    end
  endtask

  task automatic drain(input string req);
    repeat (4) @(negedge clk);
    chk(exp_ch.size() == 0, req, "results missing", exp_ch.size(), 0);
  endtask

  task automatic t_reset();
    cur_req = "R8";
    do_reset();
    chk(out_valid == 0, "R8", "out_valid after reset", int'(out_valid), 0);
    chk(out_mag == 0, "R8", "out_mag after reset", int'(out_mag), 0);
  endtask

  task automatic t_dc();
    do_reset(); cur_req = "R10";
    run(0, 20 * (M + 2));
    drain("R10");
    chk(nout == K * 3, "R5", "result count after M+2 cycles", nout, K * 3);
  endtask

  task automatic t_early();
    do_reset(); cur_req = "R5";
    run(1, 20 * (M - 1));
    repeat (4) @(negedge clk);
    chk(nout == 0, "R5", "results before M cycles", nout, 0);
    run(1, 20);
    drain("R5");
    chk(nout == K, "R5", "results at M-th cycle", nout, K);
  endtask

  task automatic t_iphase();
    do_reset(); cur_req = "R2";
    run(1, 20 * (M + 2));
    cur_req = "R4";
    run(5, 20 * 4);
    drain("R4");
  endtask

  task automatic t_qphase();
    do_reset(); cur_req = "R3";
    run(2, 20 * (M + 1));
    drain("R3");
  endtask

  task automatic t_group();
    do_reset(); cur_req = "R1";
    run(3, 20 * (M + 2));
    drain("R1");
  endtask

  task automatic t_full();
    do_reset(); cur_req = "R9";
    run(4, 20 * M);
    repeat (4) @(negedge clk);
    chk(nout == K, "R9", "full-scale result count", nout, K);
    chk(int'(out_mag) == 10 * M * 4095, "R9", "full-scale magnitude", int'(out_mag), 10 * M * 4095);
    drain("R9");
  endtask

  task automatic t_sync();
    do_reset(); cur_req = "R6";
    run(3, 20 * M + 7);
    for (int c = 0; c < K; c++) vals[c] = pat(3, c, 0);
    tick(1);
    run(3, 20 * 3 - 1);
    drain("R6");
  endtask

  task automatic t_gap();
    do_reset(); cur_req = "R7";
    gap = 5;
    run(5, 20 * (M + 1));
    drain("R7");
    gap = 0;
  endtask

  initial begin
    gap = 0;
    t_reset();
    t_dc();
    t_early();
    t_iphase();
    t_qphase();
    t_group();
    t_full();
    t_sync();
    t_gap();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule